// File: doc/BRIEF.md
# Destination Flow Control Arbiter

This block tracks congestion toward up to sixteen remote destinations and tells each local transmit source whether it must hold off. It keeps a table of flows, each a destination ID with an ID-size type, and a saturating count of outstanding Xoff requests per flow. Incoming Xoff and Xon events carry a destination ID and a size flag. An Xoff raises the count of every flow it matches and an Xon lowers it. A flow whose count is nonzero is shown as set in a 16-bit Xoff status vector.

Each of the twenty transmit sources owns a flow mask: four load/store units and sixteen transmit queues. A source is stalled while any flow selected by its mask is in the Xoff state. A simple word-wide register port writes and reads the flow table and the masks. Both reads and stall outputs are combinational from the stored state.

Register map (word addresses, default parameters):
- Flow entries sit at 0x00 to 0x0F, one per flow.
- Load/store unit masks sit at 0x10 to 0x13.
- Transmit queue mask pairs sit at 0x20 to 0x27.
- Every other address reads as zero.

Top module: `dfc_arbiter`

## Requirements
- R1: After reset every Xoff count is zero, so `xoff_vec` and all stall outputs are zero. Flow entries read 0, load/store mask registers read 0x0000FFFF, and queue pair registers read 0xFFFFFFFF.
- R2: A flow entry register holds the destination ID in bits 15:0 and the transfer type in bits 17:16. Bits 31:18 always read as zero, whatever was written to them.
- R3: Type 00 selects 8-bit IDs. Such an entry matches a narrow event (`ev_wide`=0) when bits 7:0 of the event ID equal bits 7:0 of the stored ID. The upper 8 bits of both are ignored.
- R4: Type 01 selects 16-bit IDs. Such an entry matches a wide event (`ev_wide`=1) only when all 16 bits are equal.
- R5: Entries of type 10 or 11 never match. An entry never matches an event whose size flag differs from its own ID size.
- R6: A valid event updates every matching entry at once: Xoff (`ev_xoff`=1) increments the count and Xon decrements it. `xoff_vec[i]` is 1 exactly when the count of flow i is nonzero.
- R7: Each count saturates at 2^CNT_W-1 on Xoff and at zero on Xon, so it never wraps.
- R8: Bit i of every mask selects flow i. A source's stall output is the OR-reduce of `xoff_vec` AND its mask. A source with an all-zero mask is never stalled.
- R9: A load/store unit mask occupies bits 15:0 of its register, and bits 31:16 read as zero. A queue pair register at 0x20+k holds queue 2k+1 in bits 15:0 and queue 2k in bits 31:16.
- R10: Writing a flow entry clears that flow's count. An event arriving in the same cycle is matched against the table contents before the write. On the written entry, the clear overrides the event's effect.
- R11: Writes and events act on the rising clock edge. Their effect on `xoff_vec` and the stall outputs is visible directly after that edge.
- R12: A write to an unmapped address changes nothing, and an unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| ev_valid | input | 1 | Flow event present this cycle |
| ev_xoff | input | 1 | 1 = Xoff, 0 = Xon |
| ev_wide | input | 1 | 1 = 16-bit destination ID, 0 = 8-bit |
| ev_dest | input | 16 | Destination ID carried by the event |
| xoff_vec | output | N_FLOWS | Per-flow Xoff status |
| lsu_stall | output | N_LSU | Stall per load/store unit |
| txq_stall | output | N_TXQ | Stall per transmit queue |

## Verification
The case where two functions meet is a register write to a flow entry in the same cycle as an event that matches that entry, either under its old contents or under its new ones. The bench raises an entry's count first. It then rewrites the entry while sending a matching Xoff, and expects the flow to read as idle afterwards. In a second case an event matches the new ID only and must count nowhere. In a third case the event matches the old ID of the entry being rewritten and also a second entry with the same ID, and only that second entry may count up. Mask writes that land while flows are in the Xoff state are judged the same way: the stall outputs must follow the new mask right after the write edge.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

   localparam int DEST_W = 16;
   localparam int NARROW_W = 8;
   localparam int WORD_W = 32;
   localparam int HALF_W = 16;

   typedef enum logic [1:0] {
      TT_ID8  = 2'b00,
      TT_ID16 = 2'b01,
      TT_RSV2 = 2'b10,
      TT_RSV3 = 2'b11
   } tt_e;

   typedef struct packed {
      tt_e               tt;
      logic [DEST_W-1:0] id;
   } flow_ent_t;

   localparam int ENT_W = $bits(flow_ent_t);

   // Decide whether an incoming event addresses a table entry.
   function automatic logic ent_match(flow_ent_t e, logic wide, logic [DEST_W-1:0] dest);
      logic hit;
      case (e.tt)
         TT_ID8:  hit = !wide && (e.id[NARROW_W-1:0] == dest[NARROW_W-1:0]);
         TT_ID16: hit = wide && (e.id == dest);
         default: hit = 1'b0;
      endcase
      return hit;
   endfunction

   function automatic flow_ent_t word_to_ent(logic [WORD_W-1:0] w);
      flow_ent_t e;
      e.tt = tt_e'(w[DEST_W +: 2]);
      e.id = w[DEST_W-1:0];
      return e;
   endfunction

   function automatic logic [WORD_W-1:0] ent_to_word(flow_ent_t e);
      return {{(WORD_W-ENT_W){1'b0}}, e};
   endfunction

endpackage

// File: rtl/dfc_sat_cnt.sv
module dfc_sat_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W == 1) begin : g_flag
         // One-bit variant: a set/reset flag.
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt <= 1'b0;
            else if (up)       cnt <= 1'b1;
            else if (dn)       cnt <= 1'b0;
         end
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || clr)            cnt <= '0;
            else if (up && cnt != TOP)    cnt <= cnt + 1'b1;
            else if (dn && cnt != '0)     cnt <= cnt - 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/dfc_flow_entry.sv
module dfc_flow_entry
   import dfc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  flow_ent_t         wr_ent,
   input  logic              ev_valid,
   input  logic              ev_xoff,
   input  logic              ev_wide,
   input  logic [DEST_W-1:0] ev_dest,
   output flow_ent_t         ent_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              xoff_on
);
   logic hit;

   always_ff @(posedge clk) begin
      if (!rst_n)     ent_q <= '0;
      else if (wr_en) ent_q <= wr_ent;
   end

   // Matching uses the stored contents, i.e. those before any write this cycle.
   assign hit = ev_valid && ent_match(ent_q, ev_wide, ev_dest);

   dfc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_en),
      .up    (hit && ev_xoff),
      .dn    (hit && !ev_xoff),
      .cnt   (cnt_q)
   );

   assign xoff_on = |cnt_q;

endmodule

// File: rtl/dfc_mask_bank.sv
module dfc_mask_bank #(
   parameter int N_FLOWS = 16,
   parameter int N_SRC   = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N_SRC-1:0]                wr_en,
   input  logic [N_SRC-1:0][N_FLOWS-1:0]   wr_mask,
   input  logic [N_FLOWS-1:0]              xoff_vec,
   output logic [N_SRC-1:0][N_FLOWS-1:0]   mask_q,
   output logic [N_SRC-1:0]                stall
);
   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n)        mask_q[s] <= {N_FLOWS{1'b1}};
            else if (wr_en[s]) mask_q[s] <= wr_mask[s];
         end
         assign stall[s] = |(xoff_vec & mask_q[s]);
      end
   endgenerate

endmodule

// File: rtl/dfc_arbiter.sv
module dfc_arbiter
   import dfc_pkg::*;
#(
   parameter int N_FLOWS  = 16,
   parameter int N_LSU    = 4,
   parameter int N_TXQ    = 16,
   parameter int CNT_W    = 4,
   parameter int ADDR_W   = 6,
   parameter int LSU_BASE = 16,
   parameter int TXQ_BASE = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               ev_valid,
   input  logic               ev_xoff,
   input  logic               ev_wide,
   input  logic [15:0]        ev_dest,
   output logic [N_FLOWS-1:0] xoff_vec,
   output logic [N_LSU-1:0]   lsu_stall,
   output logic [N_TXQ-1:0]   txq_stall
);
   localparam int ENT_BASE = 0;
   localparam int N_PAIR   = N_TXQ / 2;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (N_FLOWS < 1 || N_FLOWS > HALF_W) begin : g_bad_flows
      $error("dfc_arbiter: N_FLOWS must be 1..16");
   end
   if (N_LSU < 1) begin : g_bad_lsu
      $error("dfc_arbiter: N_LSU must be at least 1");
   end
   if (N_TXQ < 2 || (N_TXQ % 2) != 0) begin : g_bad_txq
      $error("dfc_arbiter: N_TXQ must be even and at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dfc_arbiter: CNT_W must be at least 1");
   end
   if (LSU_BASE < ENT_BASE + N_FLOWS || TXQ_BASE < LSU_BASE + N_LSU) begin : g_bad_map
      $error("dfc_arbiter: register regions overlap");
   end
   if (TXQ_BASE + N_PAIR > ADDR_SPAN) begin : g_bad_addr
      $error("dfc_arbiter: ADDR_W too small for register map");
   end

   flow_ent_t                         wr_ent;
   flow_ent_t [N_FLOWS-1:0]           ent_all;
   logic [N_FLOWS-1:0][CNT_W-1:0]     cnt_all;
   logic [N_FLOWS-1:0]                ent_wr;
   logic [N_LSU-1:0]                  lsu_wr;
   logic [N_LSU-1:0][N_FLOWS-1:0]     lsu_wdata;
   logic [N_LSU-1:0][N_FLOWS-1:0]     lsu_mask_all;
   logic [N_TXQ-1:0]                  txq_wr;
   logic [N_TXQ-1:0][N_FLOWS-1:0]     txq_wdata;
   logic [N_TXQ-1:0][N_FLOWS-1:0]     txq_mask_all;

   assign wr_ent = word_to_ent(cfg_wdata);

   // Flow table
   generate
      for (genvar i = 0; i < N_FLOWS; i++) begin : g_flow
         localparam logic [ADDR_W-1:0] A = ADDR_W'(ENT_BASE + i);
         assign ent_wr[i] = cfg_wr && (cfg_addr == A);
         dfc_flow_entry #(.CNT_W(CNT_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ent_wr[i]),
            .wr_ent   (wr_ent),
            .ev_valid (ev_valid),
            .ev_xoff  (ev_xoff),
            .ev_wide  (ev_wide),
            .ev_dest  (ev_dest),
            .ent_q    (ent_all[i]),
            .cnt_q    (cnt_all[i]),
            .xoff_on  (xoff_vec[i])
         );
      end
   endgenerate

   // Load/store unit masks: one per register, low half
   generate
      for (genvar j = 0; j < N_LSU; j++) begin : g_lsu_dec
         localparam logic [ADDR_W-1:0] A = ADDR_W'(LSU_BASE + j);
         assign lsu_wr[j]    = cfg_wr && (cfg_addr == A);
         assign lsu_wdata[j] = cfg_wdata[N_FLOWS-1:0];
      end
   endgenerate

   // Transmit queue masks: two per register, odd queue low, even queue high
   generate
      for (genvar k = 0; k < N_PAIR; k++) begin : g_txq_dec
         localparam logic [ADDR_W-1:0] A = ADDR_W'(TXQ_BASE + k);
         logic sel;
         assign sel                = cfg_wr && (cfg_addr == A);
         assign txq_wr[2*k]        = sel;
         assign txq_wr[2*k+1]      = sel;
         assign txq_wdata[2*k+1]   = cfg_wdata[N_FLOWS-1:0];
         assign txq_wdata[2*k]     = cfg_wdata[HALF_W +: N_FLOWS];
      end
   endgenerate

   dfc_mask_bank #(.N_FLOWS(N_FLOWS), .N_SRC(N_LSU)) u_lsu_masks (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lsu_wr),
      .wr_mask  (lsu_wdata),
      .xoff_vec (xoff_vec),
      .mask_q   (lsu_mask_all),
      .stall    (lsu_stall)
   );

   dfc_mask_bank #(.N_FLOWS(N_FLOWS), .N_SRC(N_TXQ)) u_txq_masks (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (txq_wr),
      .wr_mask  (txq_wdata),
      .xoff_vec (xoff_vec),
      .mask_q   (txq_mask_all),
      .stall    (txq_stall)
   );

   // Read mux
   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < N_FLOWS; i++) begin
         if (cfg_addr == ADDR_W'(ENT_BASE + i)) cfg_rdata = ent_to_word(ent_all[i]);
      end
      for (int j = 0; j < N_LSU; j++) begin
         if (cfg_addr == ADDR_W'(LSU_BASE + j)) cfg_rdata = WORD_W'(lsu_mask_all[j]);
      end
      for (int k = 0; k < N_PAIR; k++) begin
         if (cfg_addr == ADDR_W'(TXQ_BASE + k))
            cfg_rdata = WORD_W'(txq_mask_all[2*k+1]) | (WORD_W'(txq_mask_all[2*k]) << HALF_W);
      end
   end

endmodule

// File: rtl/dfc_arbiter_chk.sv
module dfc_arbiter_chk #(
   parameter int N_FLOWS  = 16,
   parameter int N_LSU    = 4,
   parameter int N_TXQ    = 16,
   parameter int CNT_W    = 4,
   parameter int ADDR_W   = 6,
   parameter int ENT_BASE = 0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_wr,
   input logic [ADDR_W-1:0]             cfg_addr,
   input logic                          ev_valid,
   input logic                          ev_xoff,
   input logic [N_FLOWS-1:0]            xoff_vec,
   input logic [N_LSU-1:0]              lsu_stall,
   input logic [N_TXQ-1:0]              txq_stall,
   input logic [N_FLOWS-1:0][CNT_W-1:0] cnt_all,
   input logic [N_LSU-1:0][N_FLOWS-1:0] lsu_mask_all,
   input logic [N_TXQ-1:0][N_FLOWS-1:0] txq_mask_all
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   generate
      for (genvar i = 0; i < N_FLOWS; i++) begin : g_flow
         localparam logic [ADDR_W-1:0] A = ADDR_W'(ENT_BASE + i);

         // R7: no wrap at the top on Xoff
         a_r7_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] == MAXV && ev_valid && ev_xoff && !(cfg_wr && cfg_addr == A))
            |=> cnt_all[i] == MAXV);

         // R7: no wrap at zero on Xon
         a_r7_hold_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] == '0 && ev_valid && !ev_xoff)
            |=> cnt_all[i] == '0);

         // R10: writing an entry leaves its count cleared
         a_r10_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_addr == A) |=> (cnt_all[i] == '0 && !xoff_vec[i]));
      end

      for (genvar j = 0; j < N_LSU; j++) begin : g_lsu
         // R8: an all-zero mask never stalls its source
         a_r8_lsu_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (lsu_mask_all[j] == '0) |-> !lsu_stall[j]);
      end

      for (genvar q = 0; q < N_TXQ; q++) begin : g_txq
         // R8: an all-zero mask never stalls its source
         a_r8_txq_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (txq_mask_all[q] == '0) |-> !txq_stall[q]);
      end
   endgenerate

   // R8: no flow in Xoff means no source is stalled
   a_r8_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_vec == '0) |-> (lsu_stall == '0 && txq_stall == '0));

   // R6/R11: without an event or a write the status vector holds
   a_r6_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid && !cfg_wr) |=> $stable(xoff_vec));

endmodule

bind dfc_arbiter dfc_arbiter_chk #(
   .N_FLOWS  (N_FLOWS),
   .N_LSU    (N_LSU),
   .N_TXQ    (N_TXQ),
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .ENT_BASE (ENT_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .cfg_addr     (cfg_addr),
   .ev_valid     (ev_valid),
   .ev_xoff      (ev_xoff),
   .xoff_vec     (xoff_vec),
   .lsu_stall    (lsu_stall),
   .txq_stall    (txq_stall),
   .cnt_all      (cnt_all),
   .lsu_mask_all (lsu_mask_all),
   .txq_mask_all (txq_mask_all)
);

// File: tb/sim_dfc_arbiter.sv
module sim_dfc_arbiter;
   localparam int NF = 16, NL = 4, NQ = 16, CW = 3, AW = 6;
   localparam int LB = 16, QB = 32;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          ev_valid = 1'b0, ev_xoff = 1'b0, ev_wide = 1'b0;
   logic [15:0]   ev_dest = '0;
   logic [NF-1:0] xoff_vec;
   logic [NL-1:0] lsu_stall;
   logic [NQ-1:0] txq_stall;

   int n_chk = 0;
   int n_err = 0;

   // Reference model state
   logic [15:0] m_id [NF];
   logic [1:0]  m_tt [NF];
   int          m_cnt [NF];
   logic [15:0] m_lm [NL];
   logic [15:0] m_qm [NQ];

   always #4 clk = ~clk;

   dfc_arbiter #(.N_FLOWS(NF), .N_LSU(NL), .N_TXQ(NQ), .CNT_W(CW), .ADDR_W(AW),
                 .LSU_BASE(LB), .TXQ_BASE(QB)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_valid(ev_valid),
      .ev_xoff(ev_xoff), .ev_wide(ev_wide), .ev_dest(ev_dest),
      .xoff_vec(xoff_vec), .lsu_stall(lsu_stall), .txq_stall(txq_stall));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Matching rules of R3, R4, R5
   function automatic bit m_match(int i, logic wide, logic [15:0] dest);
      if (m_tt[i] == 2'b00) return !wide && (m_id[i][7:0] == dest[7:0]);
      if (m_tt[i] == 2'b01) return wide && (m_id[i] == dest);
      return 0;
   endfunction

   function automatic logic [15:0] m_vec();
      logic [15:0] v = '0;
      for (int i = 0; i < NF; i++) v[i] = (m_cnt[i] != 0);
      return v;
   endfunction

   function automatic logic [31:0] m_reg(int a);
      if (a < NF) return {14'b0, m_tt[a], m_id[a]};
      if (a >= LB && a < LB + NL) return {16'b0, m_lm[a-LB]};
      if (a >= QB && a < QB + NQ/2) return {m_qm[2*(a-QB)], m_qm[2*(a-QB)+1]};
      return 32'h0;
   endfunction

   task automatic check_out(input string req);
      logic [15:0] v = m_vec();
      logic [NL-1:0] el;
      logic [NQ-1:0] eq;
      for (int j = 0; j < NL; j++) el[j] = |(v & m_lm[j]);
      for (int q = 0; q < NQ; q++) eq[q] = |(v & m_qm[q]);
      chk({req, " xoff_vec"}, 32'(xoff_vec), 32'(v));
      chk({req, " lsu_stall"}, 32'(lsu_stall), 32'(el));
      chk({req, " txq_stall"}, 32'(txq_stall), 32'(eq));
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < (1 << AW); a++) begin
         cfg_addr = AW'(a);
         #1;
         chk(req, cfg_rdata, m_reg(a));
      end
   endtask

   // One cycle of stimulus; called at a falling edge, returns at the next one.
   task automatic step(input bit do_wr, input int addr, input logic [31:0] data,
                       input bit do_ev, input bit xoff, input bit wide,
                       input logic [15:0] dest, input string req);
      cfg_wr = do_wr; cfg_addr = AW'(addr); cfg_wdata = data;
      ev_valid = do_ev; ev_xoff = xoff; ev_wide = wide; ev_dest = dest;
      // model: event first, against the table before the write (R10)
      if (do_ev) begin
         for (int i = 0; i < NF; i++) begin
            if (m_match(i, wide, dest)) begin
               if (xoff && m_cnt[i] < MAXC) m_cnt[i]++;
               if (!xoff && m_cnt[i] > 0)   m_cnt[i]--;
            end
         end
      end
      if (do_wr) begin
         if (addr < NF) begin
            m_id[addr] = data[15:0]; m_tt[addr] = data[17:16]; m_cnt[addr] = 0;
         end else if (addr >= LB && addr < LB + NL) begin
            m_lm[addr-LB] = data[15:0];
         end else if (addr >= QB && addr < QB + NQ/2) begin
            m_qm[2*(addr-QB)+1] = data[15:0];
            m_qm[2*(addr-QB)]   = data[31:16];
         end
      end
      @(negedge clk);
      cfg_wr = 1'b0; ev_valid = 1'b0;
      check_out(req);
   endtask

   task automatic wr(input int addr, input logic [31:0] data, input string req);
      step(1, addr, data, 0, 0, 0, 16'h0, req);
   endtask

   task automatic ev(input bit xoff, input bit wide, input logic [15:0] dest, input string req);
      step(0, 0, 32'h0, 1, xoff, wide, dest, req);
   endtask

   function automatic logic [31:0] ent_word(int i);
      case (i)
         0: return 32'h0000_1234;
         1: return 32'h0000_5634;
         2: return 32'h0001_1234;
         3: return 32'h0002_1234;
         4: return 32'h0003_1234;
         default: return {14'b0, 2'(i % 2), 8'(i * 17), 8'(i * 29)};
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < NF; i++) begin m_id[i] = '0; m_tt[i] = '0; m_cnt[i] = 0; end
      for (int j = 0; j < NL; j++) m_lm[j] = 16'hFFFF;
      for (int q = 0; q < NQ; q++) m_qm[q] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_out("R1");
      read_all("R1");

      // R2: program table with junk in reserved bits
      for (int i = 0; i < NF; i++) wr(i, ent_word(i) | 32'hFFFC_0000, "R2");
      read_all("R2");

      // R9: mask programming and packing
      wr(LB + 0, 32'hFFFF_00FF, "R9");
      wr(LB + 1, 32'h0000_F00F, "R9");
      wr(LB + 2, 32'h1234_0004, "R9");
      wr(LB + 3, 32'h0000_0000, "R9");
      for (int k = 0; k < NQ/2; k++) begin
         logic [15:0] hi = 16'(16'h1 << k) | 16'h0100;
         logic [15:0] lo = 16'(16'h8000 >> k);
         if (k == 7) lo = 16'h0000;
         wr(QB + k, {hi, lo}, "R9");
      end
      read_all("R9");

      // R3/R4/R5/R6/R11: event sweep over every entry
      for (int i = 0; i < NF; i++) begin
         ev(1, 0, m_id[i], "R3");
         ev(1, 1, m_id[i], "R4");
         ev(1, 0, m_id[i] ^ 16'hFF00, "R3");
         ev(1, 1, m_id[i] ^ 16'h0100, "R5");
      end
      for (int i = 0; i < NF; i++) begin
         ev(0, 0, m_id[i], "R6");
         ev(0, 1, m_id[i], "R6");
      end
      for (int i = 0; i < NF; i++) begin
         for (int r = 0; r <= MAXC; r++) begin
            ev(0, 0, m_id[i], "R6");
            ev(0, 1, m_id[i], "R6");
         end
      end
      chk("R6 drained", 32'(xoff_vec), 32'h0);

      // R7: saturation on entry 2 (wide 0x1234)
      for (int r = 0; r < MAXC + 2; r++) ev(1, 1, 16'h1234, "R7");
      for (int r = 0; r < MAXC - 1; r++) ev(0, 1, 16'h1234, "R7");
      chk("R7 still set", 32'(xoff_vec[2]), 32'h1);
      ev(0, 1, 16'h1234, "R7");
      chk("R7 cleared", 32'(xoff_vec[2]), 32'h0);
      ev(0, 1, 16'h1234, "R7");
      ev(1, 1, 16'h1234, "R7");
      chk("R7 floor", 32'(xoff_vec[2]), 32'h1);
      ev(0, 1, 16'h1234, "R7");

      // R8: single-bit mask sweep with flow 5 in Xoff
      ev(1, m_tt[5][0], m_id[5], "R8");
      for (int b = 0; b < NF; b++) begin
         wr(LB + 0, 32'(16'h1 << b), "R8");
         wr(QB + 0, {16'(16'h1 << b), ~16'(16'h1 << b)}, "R8");
      end
      wr(LB + 1, 32'h0, "R8");
      ev(1, 1, 16'h1234, "R8");
      ev(1, 0, 16'h0034, "R8");

      // R10: entry write in the same cycle as a matching event
      ev(1, m_tt[6][0], m_id[6], "R10");
      ev(1, m_tt[6][0], m_id[6], "R10");
      step(1, 6, ent_word(6), 1, 1, m_tt[6][0], m_id[6], "R10");
      chk("R10 cleared", 32'(xoff_vec[6]), 32'h0);
      step(1, 7, 32'h0001_0777, 1, 1, 1, 16'h0777, "R10");
      chk("R10 new id no count", 32'(xoff_vec[7]), 32'h0);
      wr(9, ent_word(8), "R10");
      step(1, 8, 32'h0001_0888, 1, 1, m_tt[8][0], m_id[8], "R10");
      chk("R10 twin counted", 32'(xoff_vec[9]), 32'h1);
      chk("R10 rewritten idle", 32'(xoff_vec[8]), 32'h0);

      // R12: unmapped addresses
      wr(63, 32'hFFFF_FFFF, "R12");
      wr(LB + NL, 32'hFFFF_FFFF, "R12");
      read_all("R12");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule